// File: doc/BRIEF.md
# Select-Routed RAM Command Interconnect

This block carries RAM write commands from a set of requesting clients to a matching set of RAM ports. It also returns a write-completion pulse to each client. The fabric has two halves. A merging stage arbitrates among the clients and forwards one command at a time. It tags that command with a routing select, which is the index of the client that won. A routing stage then sends the command to the RAM port named by the select. The address is never used for routing and is never changed. Clients only present an address, data and byte enables. They have no select pin. The RAM ports also carry no select, because the routing stage uses all of it.

Every command channel is valid/ready. A source raises valid and holds the command stable until it sees ready in the same cycle, and a transfer happens on the clock edge where both are high. A RAM port may hold ready low for as long as it likes, and the command stays on that port for the whole stall. The routing stage writes the select of every accepted command into a tracking queue. RAM completions can arrive in any order across ports. They are handed back to the clients strictly in the order the commands were issued, one completion per cycle.

Client count, address, data and byte-enable widths, and the tracking depth are all parameters. The select width is derived from the client count.

Top module: `ramcmd_xbar`

## Requirements
- R1: While rst_n is low, and right after it rises, no RAM port shows valid and no client receives a done pulse.
- R2: A command from client i appears on RAM port i in the same cycle. The address, data and byte enables are bit-for-bit unchanged. Client i's fields occupy slices [i*W +: W] of the packed buses, and RAM port i uses the same slices.
- R3: When several clients are valid and the RAM side is ready, one command is accepted per cycle. The search starts at the index after the last winner and wraps. After reset it starts at index 0.
- R4: While the granted command waits on a RAM port whose ready is low, the grant does not move. The RAM-side valid and address stay stable, and no client sees ready, even if other clients become valid.
- R5: At most one RAM port shows valid in any cycle. A client sees ready only while its own valid is high and it holds the grant.
- R6: A done pulse on RAM port i, sampled at a rising edge, produces a one-cycle done pulse on client i that is visible in the following cycle.
- R7: Done pulses reach the clients in the order the commands were accepted. A completion from a port whose command is not the oldest outstanding one is held until its turn.
- R8: The tracking queue holds up to TRK_DEPTH outstanding commands. When it is full, no RAM port shows valid and no client sees ready, until a completion retires the oldest command.
- R9: At most one client done pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cl_valid | input | N_PORTS | Per-client command valid |
| cl_ready | output | N_PORTS | Per-client command ready |
| cl_addr | input | N_PORTS*ADDR_W | Packed client addresses |
| cl_data | input | N_PORTS*DATA_W | Packed client write data |
| cl_be | input | N_PORTS*BE_W | Packed client byte enables |
| cl_done | output | N_PORTS | Per-client write-done pulse |
| ram_valid | output | N_PORTS | Per-RAM-port command valid |
| ram_ready | input | N_PORTS | Per-RAM-port command ready |
| ram_addr | output | N_PORTS*ADDR_W | Packed RAM addresses |
| ram_data | output | N_PORTS*DATA_W | Packed RAM write data |
| ram_be | output | N_PORTS*BE_W | Packed RAM byte enables |
| ram_done | input | N_PORTS | Per-RAM-port write-done pulse |

## Verification
Commands have no register on the forward path. A client's command is therefore due on its RAM port in the same cycle it is offered, and the bench samples both sides at the falling edge of that cycle. A completion driven on a RAM port is registered once. The matching client pulse is due one cycle after the rising edge that samples the RAM pulse. The directed checks look exactly one falling edge after the pulse was removed, and they also confirm the client pulse is still absent at the falling edge before that. A scoreboard records issue order from the RAM-side handshakes and compares every client done pulse against it, so held and reordered completions are checked without timing assumptions.

// File: rtl/ramx_pkg.sv
package ramx_pkg;

  // Bits needed to index n items; never below one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ramx_done_fifo.sv
module ramx_done_fifo
  import ramx_pkg::*;
#(
  parameter int W     = 2,
  parameter int DEPTH = 8,
  localparam int AW   = idx_bits(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_q, rd_q;

  assign empty = (wr_q == rd_q);
  assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign head  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
    end
  end

endmodule

// File: rtl/ramx_rr_mux.sv
module ramx_rr_mux
  import ramx_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  localparam int IW    = idx_bits(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        in_valid,
  output logic [N-1:0]        in_ready,
  input  logic [N*ADDR_W-1:0] in_addr,
  input  logic [N*DATA_W-1:0] in_data,
  input  logic [N*BE_W-1:0]   in_be,
  output logic [N-1:0]        in_done,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [IW-1:0]       out_sel,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [DATA_W-1:0]   out_data,
  output logic [BE_W-1:0]     out_be,
  input  logic                done_valid,
  input  logic [IW-1:0]       done_sel
);

  logic [IW-1:0] ptr_q, gnt_q, pick, gnt;
  logic          lock_q;

  // Round-robin search beginning at ptr_q; the lowest offset wins.
  always_comb begin
    pick = ptr_q;
    for (int k = N - 1; k >= 0; k--) begin
      int c;
      c = (int'(ptr_q) + k) % N;
      if (in_valid[c]) pick = IW'(c);
    end
  end

  assign gnt       = lock_q ? gnt_q : pick;
  assign out_valid = in_valid[gnt];
  assign out_sel   = gnt;  // the winner's index becomes the routing select
  assign out_addr  = in_addr[int'(gnt)*ADDR_W +: ADDR_W];
  assign out_data  = in_data[int'(gnt)*DATA_W +: DATA_W];
  assign out_be    = in_be[int'(gnt)*BE_W +: BE_W];

  for (genvar i = 0; i < N; i++) begin : g_port
    assign in_ready[i] = in_valid[i] && out_ready && (gnt == IW'(i));
    assign in_done[i]  = done_valid && (done_sel == IW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      gnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      lock_q <= out_valid && !out_ready;
      gnt_q  <= gnt;
      if (out_valid && out_ready)
        ptr_q <= (int'(gnt) == N - 1) ? '0 : gnt + IW'(1);
    end
  end

endmodule

// File: rtl/ramx_sel_demux.sv
module ramx_sel_demux
  import ramx_pkg::*;
#(
  parameter int M      = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int DEPTH  = 8,
  localparam int IW    = idx_bits(M)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IW-1:0]       in_sel,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [BE_W-1:0]     in_be,
  output logic [M-1:0]        out_valid,
  input  logic [M-1:0]        out_ready,
  output logic [M*ADDR_W-1:0] out_addr,
  output logic [M*DATA_W-1:0] out_data,
  output logic [M*BE_W-1:0]   out_be,
  input  logic [M-1:0]        out_done,
  output logic                done_valid,
  output logic [IW-1:0]       done_sel
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          full, empty, push, pop, sel_ready, head_ok;
  logic [IW-1:0] head_sel;
  logic [CW-1:0] credit_q [M];

  ramx_done_fifo #(.W(IW), .DEPTH(DEPTH)) u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (in_sel),
    .pop   (pop),
    .head  (head_sel),
    .empty (empty),
    .full  (full)
  );

  always_comb begin
    sel_ready = 1'b0;
    head_ok   = 1'b0;
    for (int m = 0; m < M; m++) begin
      if (in_sel == IW'(m))   sel_ready = out_ready[m];
      if (head_sel == IW'(m)) head_ok   = (credit_q[m] != '0) || out_done[m];
    end
  end

  assign in_ready = !full && sel_ready;
  assign push     = in_valid && in_ready;
  assign pop      = !empty && head_ok;

  // Select is consumed entirely here; RAM ports carry none.
  for (genvar m = 0; m < M; m++) begin : g_ram
    assign out_valid[m]                  = in_valid && !full && (in_sel == IW'(m));
    assign out_addr[m*ADDR_W +: ADDR_W]  = in_addr;
    assign out_data[m*DATA_W +: DATA_W]  = in_data;
    assign out_be[m*BE_W +: BE_W]        = in_be;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < M; m++) credit_q[m] <= '0;
      done_valid <= 1'b0;
      done_sel   <= '0;
    end else begin
      for (int m = 0; m < M; m++)
        credit_q[m] <= credit_q[m] + CW'(out_done[m])
                       - CW'(pop && (head_sel == IW'(m)));
      done_valid <= pop;
      done_sel   <= head_sel;
    end
  end

endmodule

// File: rtl/ramcmd_xbar.sv
module ramcmd_xbar
  import ramx_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BE_W      = DATA_W / 8,
  parameter int TRK_DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        cl_valid,
  output logic [N_PORTS-1:0]        cl_ready,
  input  logic [N_PORTS*ADDR_W-1:0] cl_addr,
  input  logic [N_PORTS*DATA_W-1:0] cl_data,
  input  logic [N_PORTS*BE_W-1:0]   cl_be,
  output logic [N_PORTS-1:0]        cl_done,
  output logic [N_PORTS-1:0]        ram_valid,
  input  logic [N_PORTS-1:0]        ram_ready,
  output logic [N_PORTS*ADDR_W-1:0] ram_addr,
  output logic [N_PORTS*DATA_W-1:0] ram_data,
  output logic [N_PORTS*BE_W-1:0]   ram_be,
  input  logic [N_PORTS-1:0]        ram_done
);

  localparam int IW = idx_bits(N_PORTS);

  logic              x_valid, x_ready, d_valid;
  logic [IW-1:0]     x_sel, d_sel;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] x_data;
  logic [BE_W-1:0]   x_be;

  ramx_rr_mux #(
    .N(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
  ) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (cl_valid),
    .in_ready   (cl_ready),
    .in_addr    (cl_addr),
    .in_data    (cl_data),
    .in_be      (cl_be),
    .in_done    (cl_done),
    .out_valid  (x_valid),
    .out_ready  (x_ready),
    .out_sel    (x_sel),
    .out_addr   (x_addr),
    .out_data   (x_data),
    .out_be     (x_be),
    .done_valid (d_valid),
    .done_sel   (d_sel)
  );

  ramx_sel_demux #(
    .M(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .DEPTH(TRK_DEPTH)
  ) u_dmx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (x_valid),
    .in_ready   (x_ready),
    .in_sel     (x_sel),
    .in_addr    (x_addr),
    .in_data    (x_data),
    .in_be      (x_be),
    .out_valid  (ram_valid),
    .out_ready  (ram_ready),
    .out_addr   (ram_addr),
    .out_data   (ram_data),
    .out_be     (ram_be),
    .out_done   (ram_done),
    .done_valid (d_valid),
    .done_sel   (d_sel)
  );

endmodule

// File: rtl/ramcmd_xbar_chk.sv
module ramcmd_xbar_chk
  import ramx_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  localparam int IW    = idx_bits(N)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        cl_valid,
  input logic [N-1:0]        cl_ready,
  input logic [N-1:0]        cl_done,
  input logic [N-1:0]        ram_valid,
  input logic [N-1:0]        ram_ready,
  input logic [N*ADDR_W-1:0] ram_addr,
  input logic                x_valid,
  input logic                x_ready,
  input logic [IW-1:0]       x_sel
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> cl_done == '0); // R1

  AST_ROUTE_BY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && x_ready) |-> (ram_valid[x_sel] && ram_ready[x_sel])); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ram_valid != '0) && ((ram_valid & ram_ready) == '0))
      |=> ($stable(ram_valid) && $stable(ram_addr))); // R4

  AST_ONE_RAM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ram_valid) <= 1); // R5

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_ready & ~cl_valid) == '0); // R5

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cl_ready)); // R5

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cl_done)); // R9

endmodule

bind ramcmd_xbar ramcmd_xbar_chk #(.N(N_PORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cl_valid  (cl_valid),
  .cl_ready  (cl_ready),
  .cl_done   (cl_done),
  .ram_valid (ram_valid),
  .ram_ready (ram_ready),
  .ram_addr  (ram_addr),
  .x_valid   (x_valid),
  .x_ready   (x_ready),
  .x_sel     (x_sel)
);

// File: tb/sim_ramcmd_xbar.sv
module sim_ramcmd_xbar;

  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int BE_W   = 4;
  localparam int DEPTH  = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [N-1:0]        cl_valid = '0;
  logic [N-1:0]        cl_ready;
  logic [N*ADDR_W-1:0] cl_addr = '0;
  logic [N*DATA_W-1:0] cl_data = '0;
  logic [N*BE_W-1:0]   cl_be = '0;
  logic [N-1:0]        cl_done;
  logic [N-1:0]        ram_valid;
  logic [N-1:0]        ram_ready = '1;
  logic [N*ADDR_W-1:0] ram_addr;
  logic [N*DATA_W-1:0] ram_data;
  logic [N*BE_W-1:0]   ram_be;
  logic [N-1:0]        ram_done;
  logic [N-1:0]        auto_pend = '0, auto_q = '0, man_done = '0;
  bit                  auto_en = 1'b0;

  int n_checks = 0;
  int n_err    = 0;

  typedef struct {
    int                port;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    logic [BE_W-1:0]   b;
  } cmd_t;

  cmd_t exp_q[$];
  int   done_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign ram_done = auto_q | man_done;

  ramcmd_xbar #(
    .N_PORTS(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .TRK_DEPTH(DEPTH)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_addr(cl_addr),
    .cl_data(cl_data), .cl_be(cl_be), .cl_done(cl_done),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_addr(ram_addr),
    .ram_data(ram_data), .ram_be(ram_be), .ram_done(ram_done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Auto RAM responder: one done pulse the cycle after each handshake.
  always @(negedge clk) auto_pend <= auto_en ? (ram_valid & ram_ready) : '0;
  always @(posedge clk) begin
    #1;
    auto_q <= auto_pend;
  end

  // Monitor: RAM-side handshakes against the expected command queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_valid != '0)
        chk($countones(ram_valid) <= 1, "R5", "single ram valid", 64'(ram_valid), 64'(0));
      for (int m = 0; m < N; m++) begin
        if (ram_valid[m] && ram_ready[m]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected ram command on port", 64'(m), 64'(0));
          end else begin
            cmd_t e;
            e = exp_q.pop_front();
            chk(e.port == m, "R3", "ram port order", 64'(m), 64'(e.port));
            chk(ram_addr[m*ADDR_W +: ADDR_W] == e.a && ram_data[m*DATA_W +: DATA_W] == e.d
                && ram_be[m*BE_W +: BE_W] == e.b, "R2", "ram fields addr",
                64'(ram_addr[m*ADDR_W +: ADDR_W]), 64'(e.a));
          end
          done_q.push_back(m);
        end
      end
    end
  end

  // Monitor: client done pulses against issue order.
  always @(negedge clk) begin
    if (rst_n && cl_done != '0) begin
      chk($onehot0(cl_done), "R9", "single client done", 64'(cl_done), 64'(0));
      for (int i = 0; i < N; i++) begin
        if (cl_done[i]) begin
          if (done_q.size() == 0) chk(1'b0, "R7", "unexpected done on client", 64'(i), 64'(0));
          else begin
            int e;
            e = done_q.pop_front();
            chk(e == i, "R7", "done order", 64'(i), 64'(e));
          end
        end
      end
    end
  end

  task automatic drive(input int i, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [BE_W-1:0] b);
    @(posedge clk); #1;
    cl_valid[i] = 1'b1;
    cl_addr[i*ADDR_W +: ADDR_W] = a;
    cl_data[i*DATA_W +: DATA_W] = d;
    cl_be[i*BE_W +: BE_W] = b;
    forever begin
      @(negedge clk);
      if (cl_ready[i]) break;
    end
    @(posedge clk); #1;
    cl_valid[i] = 1'b0;
  endtask

  task automatic expect_cmd(input int i, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d, input logic [BE_W-1:0] b);
    cmd_t e;
    e.port = i; e.a = a; e.d = d; e.b = b;
    exp_q.push_back(e);
  endtask

  task automatic send(input int i, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [BE_W-1:0] b);
    expect_cmd(i, a, d, b);
    drive(i, a, d, b);
  endtask

  task automatic pulse(input int m);
    @(posedge clk); #1;
    man_done[m] = 1'b1;
    @(posedge clk); #1;
    man_done[m] = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    for (int k = 0; k < 200; k++) begin
      if (exp_q.size() == 0 && done_q.size() == 0) break;
      @(posedge clk);
    end
    chk(exp_q.size() == 0, tag, "commands left", 64'(exp_q.size()), 64'(0));
    chk(done_q.size() == 0, tag, "dones left", 64'(done_q.size()), 64'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 64'(0), 64'(1));
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    // R1: quiet during and after reset
    repeat (3) begin
      @(negedge clk);
      chk(ram_valid == '0 && cl_done == '0 && cl_ready == '0, "R1", "reset outputs",
          64'({ram_valid, cl_done}), 64'(0));
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(ram_valid == '0 && cl_done == '0, "R1", "after reset", 64'({ram_valid, cl_done}), 64'(0));

    // R2 / R6: one command per client, automatic completion
    auto_en = 1'b1;
    for (int i = 0; i < N; i++)
      send(i, ADDR_W'(16'h1000 + i * 16'h11), 32'hA500_0000 + 32'(i), BE_W'(4'h1 << i));
    send(1, 16'hBEEF, 32'h1234_5678, 4'hF);
    wait_idle("R2");

    // R3: all four valid at once; last winner was 1, so order is 2,3,0,1
    expect_cmd(2, 16'h2002, 32'hC0DE_0002, 4'h3);
    expect_cmd(3, 16'h2003, 32'hC0DE_0003, 4'hC);
    expect_cmd(0, 16'h2000, 32'hC0DE_0000, 4'h5);
    expect_cmd(1, 16'h2001, 32'hC0DE_0001, 4'hA);
    fork
      drive(0, 16'h2000, 32'hC0DE_0000, 4'h5);
      drive(1, 16'h2001, 32'hC0DE_0001, 4'hA);
      drive(2, 16'h2002, 32'hC0DE_0002, 4'h3);
      drive(3, 16'h2003, 32'hC0DE_0003, 4'hC);
    join
    wait_idle("R3");

    // R4: stall port 1; client 2 arrives mid-stall but must not steal the grant
    ram_ready[1] = 1'b0;
    expect_cmd(1, 16'h3111, 32'h0000_3111, 4'hF);
    expect_cmd(2, 16'h3222, 32'h0000_3222, 4'h1);
    fork
      drive(1, 16'h3111, 32'h0000_3111, 4'hF);
      begin
        repeat (2) @(posedge clk);
        drive(2, 16'h3222, 32'h0000_3222, 4'h1);
      end
      begin
        @(posedge clk); #1;
        repeat (5) begin
          @(negedge clk);
          chk(ram_valid == 4'b0010 && ram_addr[ADDR_W +: ADDR_W] == 16'h3111 && cl_ready == '0,
              "R4", "stalled grant held", 64'({ram_valid, cl_ready, ram_addr[ADDR_W +: ADDR_W]}),
              64'({4'b0010, 4'b0000, 16'h3111}));
        end
        @(posedge clk); #1;
        ram_ready[1] = 1'b1;
      end
    join
    wait_idle("R4");

    // R6: done latency, manual completion
    auto_en = 1'b0;
    repeat (2) @(posedge clk);
    send(2, 16'h4002, 32'h0000_4002, 4'h2);
    @(posedge clk); #1;
    man_done[2] = 1'b1;
    @(negedge clk);
    chk(cl_done == '0, "R6", "done not early", 64'(cl_done), 64'(0));
    @(posedge clk); #1;
    man_done[2] = 1'b0;
    @(negedge clk);
    chk(cl_done == 4'b0100, "R6", "done one cycle later", 64'(cl_done), 64'(4'b0100));
    @(negedge clk);
    chk(cl_done == '0, "R6", "done is one cycle", 64'(cl_done), 64'(0));

    // R7: RAM 1 completes before RAM 0; clients see 0 then 1
    send(0, 16'h5000, 32'h0000_5000, 4'hF);
    send(1, 16'h5001, 32'h0000_5001, 4'hF);
    pulse(1);
    @(negedge clk);
    chk(cl_done == '0, "R7", "younger done held", 64'(cl_done), 64'(0));
    @(negedge clk);
    chk(cl_done == '0, "R7", "younger done still held", 64'(cl_done), 64'(0));
    pulse(0);
    @(negedge clk);
    chk(cl_done == 4'b0001, "R7", "oldest done first", 64'(cl_done), 64'(4'b0001));
    @(negedge clk);
    chk(cl_done == 4'b0010, "R7", "held done next", 64'(cl_done), 64'(4'b0010));
    wait_idle("R7");

    // R8: fill the tracker, then a further command must wait
    for (int k = 0; k < DEPTH; k++)
      send(3, ADDR_W'(16'h6000 + k), 32'(k), 4'hF);
    expect_cmd(3, 16'h6FFF, 32'hFFFF_0000, 4'h9);
    fork
      drive(3, 16'h6FFF, 32'hFFFF_0000, 4'h9);
      begin
        @(posedge clk); #1;
        repeat (4) begin
          @(negedge clk);
          chk(cl_ready == '0 && ram_valid == '0, "R8", "full tracker blocks",
              64'({cl_ready, ram_valid}), 64'(0));
        end
        pulse(3);
      end
    join
    for (int k = 0; k < DEPTH; k++) pulse(3);
    wait_idle("R8");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule